// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets an on-chip request port read and write an external asynchronous static RAM that is sixteen bits wide. A requester presents a word address, write data, a two-bit byte enable and a read/write flag under a valid/ready handshake. Read data returns with a one-cycle valid pulse. The controller runs the memory's active-low chip select, write strobe, output enable and two byte-lane strobes from a clocked state machine. The data bus leaves the block as a split output / per-lane output-enable / input triple, and the pad ring joins them into the bidirectional bus.

Each access follows the same sequence. First comes a setup cycle, in which the address is already valid and every strobe is still high. Next come the strobe cycles. A write ends with one recovery cycle and a read ends with a turnaround gap. The strobe and gap lengths are given as nanosecond minimums together with the clock period in picoseconds. The controller rounds each one up to whole clock cycles, with a floor of one cycle. The address may move only while every strobe is high. A request whose byte enable is zero touches the memory not at all.

Top module: `asram_ctrl`

## Requirements
- R1: During and right after reset, `req_ready` is 1, chip select, write strobe and output enable are high, both lane strobes are high, no lane drives the bus and `rsp_valid` is 0.
- R2: A read with a non-zero byte enable holds chip select and output enable low and the write strobe high for exactly RD_CYC = max(1, ceil(RD_NS*1000/CLK_PS)) cycles. `rsp_valid` rises RD_CYC+2 cycles after the accepting edge and stays high for one cycle.
- R3: Read data holds the memory word for each lane whose enable bit is set (bit 0 selects data bits 7:0, bit 1 selects bits 15:8) and zero for each lane whose enable bit is clear.
- R4: During a write, chip select, the write strobe and the enabled lane strobes are low together for exactly WR_CYC = max(1, ceil(WP_NS*1000/CLK_PS), ceil(DS_NS*1000/CLK_PS)) cycles, and output enable stays high.
- R5: A lane drives the bus only during a write access and only when its enable bit is set, and it drives the request's data. Every lane whose strobe is low during a write is being driven.
- R6: `mem_addr` never changes on an edge that is next to a cycle with any strobe low. Every access is framed by a cycle with all strobes high.
- R7: No lane drives while output enable is low. After the last read cycle, at least TA_CYC = max(1, ceil(TA_NS*1000/CLK_PS)) turnaround cycles plus one idle cycle pass before any lane drives.
- R8: A request with byte enable 0 asserts no memory strobe. A read of this kind returns `rsp_valid` with data 0 one cycle after acceptance. Both kinds leave `req_ready` high.
- R9: `req_ready` is high only when the controller is idle. It returns WR_CYC+3 cycles after a write is accepted and RD_CYC+TA_CYC+2 cycles after a read is accepted.
- R10: A write with one lane enabled leaves the other lane of that word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte-lane enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DATA_W | Read data, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_bs_n | output | DATA_W/8 | Lane strobes, active low, bit 0 = bits 7:0 |
| mem_dq_o | output | DATA_W | Data to the pads |
| mem_dq_oe | output | DATA_W/8 | Per-lane pad drive enable |
| mem_dq_i | input | DATA_W | Data from the pads |

## Verification
A corrupted state register or wait counter shows up at the pins at once, on the next access. A strobe is held for the wrong number of cycles, the address moves while a strobe is low, or `req_ready` never comes back and the run hangs. A wrong lane-enable latch shows up as a lane driven without its strobe, or as a clobbered neighbour byte. Such a byte is found when the word is read back after a sweep over every address. A missing turnaround shows up as a lane drive that starts too soon after output enable rises, and it is caught on the first read that is followed by a write.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_READ,
        ST_WRITE,
        ST_RECOVER,
        ST_TURN
    } ctrl_state_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } mem_ctl_t;

    // Round a nanosecond minimum up to whole clock cycles, floor of one.
    function automatic int ns_to_cyc(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_lane.sv
module asram_lane #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LANE_W-1:0] wdata,
    input  logic              en,
    input  logic              active,
    input  logic              drive,
    input  logic              capture,
    input  logic              clear,
    input  logic [LANE_W-1:0] din,
    output logic              strobe_n,
    output logic [LANE_W-1:0] dout,
    output logic              doe,
    output logic [LANE_W-1:0] rdata
);
    logic [LANE_W-1:0] wdata_q;
    logic [LANE_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (load)         wdata_q <= wdata;
            if (clear)        rdata_q <= '0;
            else if (capture) rdata_q <= en ? din : '0;
        end
    end

    assign strobe_n = !(active && en);
    assign doe      = drive && en;
    assign dout     = wdata_q;
    assign rdata    = rdata_q;
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int RD_CYC = 1,
    parameter int WR_CYC = 1,
    parameter int TA_CYC = 1,
    parameter int CNT_W  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LANES-1:0] req_be,
    output logic             req_ready,
    output logic             accept,
    output logic [LANES-1:0] be_q,
    output logic             lane_active,
    output logic             drive,
    output logic             capture,
    output logic             clear_rd,
    output logic             rsp_valid,
    output mem_ctl_t         ctl
);
    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);

    ctrl_state_t      state_q, state_d;
    logic             wr_q;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_done;

    asram_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign clear_rd  = accept && !req_write && (req_be == '0);
    assign capture   = (state_q == ST_READ) && cnt_done;

    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (accept && (req_be != '0)) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                cnt_load = 1'b1;
                if (wr_q) begin
                    state_d = ST_WRITE;
                    cnt_val = WR_LD;
                end else begin
                    state_d = ST_READ;
                    cnt_val = RD_LD;
                end
            end
            ST_READ: begin
                if (cnt_done) begin
                    state_d  = ST_TURN;
                    cnt_load = 1'b1;
                    cnt_val  = TA_LD;
                end
            end
            ST_WRITE: begin
                if (cnt_done) state_d = ST_RECOVER;
            end
            ST_RECOVER: state_d = ST_IDLE;
            ST_TURN: begin
                if (cnt_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            wr_q      <= 1'b0;
            be_q      <= '0;
            rsp_valid <= 1'b0;
        end else begin
            state_q   <= state_d;
            rsp_valid <= capture || clear_rd;
            if (accept) begin
                wr_q <= req_write;
                be_q <= req_be;
            end
        end
    end

    assign lane_active = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign drive       = ((state_q == ST_SETUP) && wr_q) ||
                         (state_q == ST_WRITE) || (state_q == ST_RECOVER);
    assign ctl.ce_n    = !lane_active;
    assign ctl.we_n    = (state_q != ST_WRITE);
    assign ctl.oe_n    = (state_q != ST_READ);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int CLK_PS = 20000,
    parameter int RD_NS  = 10,
    parameter int WP_NS  = 8,
    parameter int DS_NS  = 6,
    parameter int TA_NS  = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [DATA_W/LANE_W-1:0] req_be,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_ce_n,
    output logic                     mem_we_n,
    output logic                     mem_oe_n,
    output logic [DATA_W/LANE_W-1:0] mem_bs_n,
    output logic [DATA_W-1:0]        mem_dq_o,
    output logic [DATA_W/LANE_W-1:0] mem_dq_oe,
    input  logic [DATA_W-1:0]        mem_dq_i
);
    localparam int LANES   = DATA_W / LANE_W;
    localparam int RD_CYC  = ns_to_cyc(RD_NS, CLK_PS);
    localparam int WR_CYC  = max2(ns_to_cyc(WP_NS, CLK_PS), ns_to_cyc(DS_NS, CLK_PS));
    localparam int TA_CYC  = ns_to_cyc(TA_NS, CLK_PS);
    localparam int MAX_CYC = max2(RD_CYC, max2(WR_CYC, TA_CYC));
    localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic             accept;
    logic [LANES-1:0] be_q;
    logic             lane_active;
    logic             drive;
    logic             capture;
    logic             clear_rd;
    mem_ctl_t         ctl;
    logic [ADDR_W-1:0] addr_q;

    asram_fsm #(
        .LANES  (LANES),
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC),
        .TA_CYC (TA_CYC),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_be      (req_be),
        .req_ready   (req_ready),
        .accept      (accept),
        .be_q        (be_q),
        .lane_active (lane_active),
        .drive       (drive),
        .capture     (capture),
        .clear_rd    (clear_rd),
        .rsp_valid   (rsp_valid),
        .ctl         (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst)         addr_q <= '0;
        else if (accept) addr_q <= req_addr;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        asram_lane #(.LANE_W(LANE_W)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .load     (accept),
            .wdata    (req_wdata[l*LANE_W +: LANE_W]),
            .en       (be_q[l]),
            .active   (lane_active),
            .drive    (drive),
            .capture  (capture),
            .clear    (clear_rd),
            .din      (mem_dq_i[l*LANE_W +: LANE_W]),
            .strobe_n (mem_bs_n[l]),
            .dout     (mem_dq_o[l*LANE_W +: LANE_W]),
            .doe      (mem_dq_oe[l]),
            .rdata    (rsp_rdata[l*LANE_W +: LANE_W])
        );
    end

    assign mem_addr = addr_q;
    assign mem_ce_n = ctl.ce_n;
    assign mem_we_n = ctl.we_n;
    assign mem_oe_n = ctl.oe_n;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [LANES-1:0]  mem_bs_n,
    input logic [LANES-1:0]  mem_dq_oe
);
    logic any_low;
    assign any_low = !mem_ce_n || !mem_we_n || !mem_oe_n || (mem_bs_n != '1);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!any_low && (mem_dq_oe == '0)));

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_dq_oe == '0));

    assert_write_shape_R4: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && (mem_bs_n != '1)));

    assert_read_shape_R2: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n && (mem_bs_n != '1)));

    assert_addr_enter_R6: assert property (@(posedge clk) disable iff (rst)
        any_low |-> $stable(mem_addr));

    assert_addr_leave_R6: assert property (@(posedge clk) disable iff (rst)
        any_low |=> $stable(mem_addr));

    assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !req_ready) |=> !rsp_valid);
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_bs_n  (mem_bs_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;
    localparam int AW     = 8;
    localparam int DEPTH  = 1 << AW;
    localparam int CLK_PS = 4000;

    function automatic int cdiv(input int ns);
        int c;
        c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int EXP_RD = cdiv(10);
    localparam int EXP_WR = (cdiv(8) > cdiv(6)) ? cdiv(8) : cdiv(6);
    localparam int EXP_TA = cdiv(5);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [1:0]  mem_bs_n;
    logic [15:0] mem_dq_o;
    logic [1:0]  mem_dq_oe;
    logic [15:0] mem_dq_i;

    always #10 clk = ~clk;

    asram_ctrl #(
        .ADDR_W (AW),
        .DATA_W (16),
        .CLK_PS (CLK_PS)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_bs_n  (mem_bs_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_i  (mem_dq_i)
    );

    int nchk = 0;
    int nerr = 0;
    logic [15:0] sram [DEPTH];
    logic [15:0] exp_mem [DEPTH];
    bit expect_quiet = 1'b0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    // Memory model: reads are combinational, writes are sampled away from the edge.
    always_comb begin
        for (int l = 0; l < 2; l++) begin
            if (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_bs_n[l])
                mem_dq_i[l*8 +: 8] = sram[mem_addr][l*8 +: 8];
            else
                mem_dq_i[l*8 +: 8] = 8'h5A;
        end
    end

    logic [AW-1:0] prev_addr = '0;
    bit  prev_low = 1'b0;
    bit  prev_drive = 1'b0;
    bit  seen_read = 1'b0;
    int  wcnt = 0;
    int  rcnt = 0;
    int  gap = 0;

    always @(negedge clk) begin
        if (!rst) begin
            bit now_low;
            now_low = !mem_ce_n || !mem_we_n || !mem_oe_n || (mem_bs_n != 2'b11);
            if (!mem_ce_n && !mem_we_n) begin
                for (int l = 0; l < 2; l++) begin
                    if (!mem_bs_n[l]) begin
                        if (!mem_dq_oe[l])
                            check(1'b0, "R5", "strobed lane not driven", l, 1);
                        sram[mem_addr][l*8 +: 8] <= mem_dq_o[l*8 +: 8];
                    end else if (mem_dq_oe[l]) begin
                        check(1'b0, "R5", "disabled lane driven", l, 0);
                    end
                end
            end
            if (!mem_oe_n && mem_dq_oe != 2'b00)
                check(1'b0, "R7", "drive while memory outputs on", mem_dq_oe, 0);
            if (mem_addr != prev_addr)
                check(!(prev_low || now_low), "R6", "address moved next to strobe",
                      mem_addr, prev_addr);
            if (expect_quiet && now_low)
                check(1'b0, "R8", "strobe on empty enable", 1, 0);
            if (!mem_we_n) wcnt++;
            else if (wcnt != 0) begin
                check(wcnt == EXP_WR, "R4", "write strobe width", wcnt, EXP_WR);
                wcnt = 0;
            end
            if (!mem_oe_n) begin
                rcnt++;
                gap = 0;
                seen_read = 1'b1;
            end else begin
                if (rcnt != 0) begin
                    check(rcnt == EXP_RD, "R2", "read strobe width", rcnt, EXP_RD);
                    rcnt = 0;
                end
                if (gap < 1000) gap++;
            end
            if (mem_dq_oe != 2'b00 && !prev_drive && seen_read)
                check(gap >= EXP_TA + 2, "R7", "turnaround gap", gap, EXP_TA + 2);
            prev_drive = (mem_dq_oe != 2'b00);
            prev_addr  = mem_addr;
            prev_low   = now_low;
        end
    end

    task automatic issue(input bit wr, input int addr, input logic [15:0] data,
                         input logic [1:0] be, output logic [15:0] rd,
                         output int rd_lat, output int rdy_lat, output bit dbl);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(addr);
        req_wdata = data;
        req_be    = be;
        rd_lat = 0;
        rdy_lat = 0;
        rd = '0;
        dbl = 1'b0;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            if (n == 1) req_valid = 1'b0;
            if (rd_lat != 0 && n == rd_lat + 1 && rsp_valid) dbl = 1'b1;
            if (rsp_valid && rd_lat == 0) begin
                rd_lat = n;
                rd = rsp_rdata;
            end
            if (req_ready && rdy_lat == 0) rdy_lat = n;
            if (rdy_lat != 0 && (wr || rd_lat != 0)) break;
        end
    endtask

    function automatic logic [15:0] pat(input int a);
        return 16'(a * 40503 + 4951);
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic do_write(input int a, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] rd;
        int rl, yl;
        bit dbl;
        expect_quiet = (be == 2'b00);
        issue(1'b1, a, d, be, rd, rl, yl, dbl);
        expect_quiet = 1'b0;
        if (be == 2'b00)
            check(yl == 1, "R8", "ready after empty write", yl, 1);
        else
            check(yl == EXP_WR + 3, "R9", "ready after write", yl, EXP_WR + 3);
        exp_mem[a] = (exp_mem[a] & ~lane_mask(be)) | (d & lane_mask(be));
    endtask

    task automatic do_read(input int a, input logic [1:0] be, input string req);
        logic [15:0] rd;
        int rl, yl;
        bit dbl;
        expect_quiet = (be == 2'b00);
        issue(1'b0, a, 16'h0, be, rd, rl, yl, dbl);
        expect_quiet = 1'b0;
        check(rd == (exp_mem[a] & lane_mask(be)), req, "read data", rd,
              exp_mem[a] & lane_mask(be));
        if (be == 2'b00) begin
            check(rl == 1, "R8", "empty read latency", rl, 1);
            check(yl == 1, "R8", "ready after empty read", yl, 1);
        end else begin
            check(rl == EXP_RD + 2, "R2", "read latency", rl, EXP_RD + 2);
            check(!dbl, "R2", "read pulse length", dbl, 0);
            check(yl == EXP_RD + EXP_TA + 2, "R9", "ready after read", yl,
                  EXP_RD + EXP_TA + 2);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", "run did not complete", 0, 1);
        finish_run();
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) begin
            sram[a] = 16'hDEAD;
            exp_mem[a] = 16'hDEAD;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        check({mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n} == 5'b11111, "R1",
              "strobes in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n}, 5'h1F);
        check(mem_dq_oe == 2'b00 && !rsp_valid, "R1", "drive/valid in reset",
              {mem_dq_oe, rsp_valid}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && mem_ce_n && mem_dq_oe == 2'b00, "R1", "idle after reset",
              {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);

        // Full-word fill of every address.
        for (int a = 0; a < DEPTH; a++) do_write(a, pat(a), 2'b11);
        // Partial writes with every enable pattern (R10 covered by later full reads).
        for (int a = 0; a < DEPTH; a++) do_write(a, ~pat(a) ^ {8'(a), 8'(a)}, 2'(a % 4));
        // R10: full readback shows untouched lanes preserved.
        for (int a = 0; a < DEPTH; a++) do_read(a, 2'b11, "R10");
        // R3: masked reads, including empty enables (R8).
        for (int a = 0; a < 64; a++) begin
            do_read(a, 2'b01, "R3");
            do_read(a, 2'b10, "R3");
            do_read(a, 2'b00, "R8");
        end
        // R7: read immediately followed by write, then readback.
        for (int a = 0; a < 32; a++) begin
            do_read(a, 2'b11, "R3");
            do_write(a, pat(a + 7), 2'b11);
            do_read(a, 2'b11, "R3");
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule